// File: doc/BRIEF.md
# Limit-Check Sticky Status Registers

This block watches a small set of sampled 8-bit measurements and turns out-of-range readings into sticky status bits that software collects through a register read port. Every voltage channel and the temperature window have a programmable low and high limit. A result is compared with its limits only in the cycle its valid strobe is high. Fan-stall flags count only while the matching PWM output is enabled. Diode fault flags, processor data and communication error events, and an over-temperature check with hysteresis feed the same status scheme.

Reading a status register clears only those bits whose fault has gone away by the read cycle. A bit whose cause is still present stays set. A second status register collects the temperature-related bits, and a summary bit in the first register shows whether any bit of the second is set. A single interrupt line is high whenever any status bit is set. The limit, over-temperature and hysteresis registers can always be written and read back.

Top module: `limit_status_top`

## Requirements
- R1: A channel flags its high limit only when the sampled value is strictly greater than the channel's high limit. A value equal to the limit sets nothing.
- R2: A channel flags its low limit when the sampled value is less than or equal to the channel's low limit.
- R3: After reset, every low limit reads 0x00, every high limit reads 0xFF, the over-temperature limit reads 100 and the hysteresis reads 4. Both status registers read 0x00 and irq_o is low.
- R4: A read of status register 1 (address 0) or status register 2 (address 1) returns the bits as they were before the read. Each window, fan or diode bit in that register is cleared only if its fault condition is absent in the read cycle; otherwise the bit stays set.
- R5: A fan bit (status 1, bits NCH+1 upward, one per fan) is set when that fan reports slow or stalled while its PWM enable is high. It is never set while the PWM enable is low.
- R6: Status 1 bit NCH is the OR of all bits of status register 2 at read time. It is not latched.
- R7: The over-temperature bit (status 2 bit 3) is set by a valid temperature above the over-temperature limit (address 4). A read of status 2 clears it only when the latest valid temperature is below the limit minus the hysteresis (address 5).
- R8: On a data error event, status 2 bits 6:4 record the error code: 0x8000 gives 000, 0x8002 gives 001, 0x8003 gives 010, and any other code gives 111. The field returns to 000 when the data error bit (bit 1) is cleared.
- R9: Address map: 2 is the temperature low limit, 3 the temperature high limit, 4 the over-temperature limit, 5 the hysteresis, 6+2i the low limit and 7+2i the high limit of channel i. Each is written by reg_wr_i and read back unchanged at any time. Unmapped addresses read 0.
- R10: The clear-on-read decision uses the condition in the read cycle. A fault that is new in the read cycle keeps its bit set (or sets it).
- R11: irq_o is high exactly when at least one status bit in either register is set.
- R12: A limit comparison happens only in a cycle where the channel's valid strobe is high. Between strobes, the fault condition is that of the last strobed sample.
- R13: The data error bit (status 2 bit 1) and the communication error bit (bit 2) are set by one-cycle events and cleared by a status 2 read unless a new event arrives in that read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_meas_i | input | NCH*DW | Packed channel samples, channel i in bits i*DW upward |
| ch_vld_i | input | NCH | Per-channel sample valid strobe |
| temp_i | input | DW | Temperature sample |
| temp_vld_i | input | 1 | Temperature sample valid strobe |
| fan_slow_i | input | NFAN | Fan below minimum speed or stalled |
| pwm_on_i | input | NFAN | PWM output enabled, one per fan |
| diode_flt_i | input | NDIO | Open or short fault on a thermal diode input |
| data_err_i | input | 1 | One-cycle processor data error event |
| err_code_i | input | 16 | Error code that goes with data_err_i |
| comm_err_i | input | 1 | One-cycle communication error event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data, valid the cycle after reg_rd_i |
| irq_o | output | 1 | Interrupt, high while any status bit is set |

## Verification
The bench builds the block with its defaults: two voltage channels, three fans, two diodes and 8-bit data. With these values, status register 1 exactly fills eight bits and the summary bit sits at bit 2. Every limit register fits in addresses 2 through 9 of a 4-bit address space, so a random read of addresses 10 through 15 covers the unmapped case. Because the data width is narrow, random samples often land exactly on a limit. That exercises the equality edges of both comparisons and the hysteresis threshold without steering the stimulus.

// File: rtl/lcs_pkg.sv
`timescale 1ns/1ps
package lcs_pkg;
    // Register addresses whose positions the software and the bench decode
    localparam int unsigned ADR_STS1 = 0;
    localparam int unsigned ADR_STS2 = 1;
    localparam int unsigned ADR_TLO  = 2;
    localparam int unsigned ADR_THI  = 3;
    localparam int unsigned ADR_OTL  = 4;
    localparam int unsigned ADR_HYS  = 5;
    localparam int unsigned ADR_CH0  = 6;

    // Bit positions inside status register 2
    localparam int unsigned S2_TWIN = 0;
    localparam int unsigned S2_DATA = 1;
    localparam int unsigned S2_COMM = 2;
    localparam int unsigned S2_OVT  = 3;
    localparam int unsigned S2_KIND = 4;

    function automatic logic [2:0] err_kind(input logic [15:0] code);
        logic [2:0] k;
        case (code)
            16'h8000: k = 3'b000;
            16'h8002: k = 3'b001;
            16'h8003: k = 3'b010;
            default:  k = 3'b111;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/lcs_window_chk.sv
`timescale 1ns/1ps
// Window comparison on a strobed sample with a sticky, clear-on-read status bit
module lcs_window_chk #(
    parameter int unsigned DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] meas_i,
    input  logic          vld_i,
    input  logic [DW-1:0] lo_i,
    input  logic [DW-1:0] hi_i,
    input  logic          rd_clr_i,
    output logic          sts_o
);
    typedef struct packed {
        logic act;   // fault condition of the last strobed sample
        logic sts;   // sticky status
    } win_t;

    win_t s_d, s_q;
    logic out_now;
    logic cond;

    always_comb begin
        out_now = vld_i && ((meas_i > hi_i) || (meas_i <= lo_i));
        cond    = vld_i ? out_now : s_q.act;
        s_d.act = cond;
        s_d.sts = (s_q.sts && !(rd_clr_i && !cond)) || out_now;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign sts_o = s_q.sts;
endmodule

// File: rtl/lcs_sticky.sv
`timescale 1ns/1ps
// Level or event fault latched until a read finds the fault absent
module lcs_sticky #(
    parameter int unsigned W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] flt_i,
    input  logic         rd_clr_i,
    output logic [W-1:0] sts_o
);
    logic [W-1:0] sts_d, sts_q;

    always_comb begin
        sts_d = (sts_q & ~({W{rd_clr_i}} & ~flt_i)) | flt_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sts_q <= '0;
        else         sts_q <= sts_d;
    end

    assign sts_o = sts_q;
endmodule

// File: rtl/lcs_overtemp.sv
`timescale 1ns/1ps
// Over-temperature flag: set above the limit, read-clear only below limit minus hysteresis
module lcs_overtemp #(
    parameter int unsigned DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] temp_i,
    input  logic          vld_i,
    input  logic [DW-1:0] lim_i,
    input  logic [DW-1:0] hys_i,
    input  logic          rd_clr_i,
    output logic          sts_o
);
    typedef struct packed {
        logic cool;  // last strobed sample below the release threshold
        logic sts;
    } ot_t;

    ot_t s_d, s_q;
    logic [DW-1:0] thr;
    logic hot;
    logic cool_now;

    always_comb begin
        thr      = (lim_i > hys_i) ? (lim_i - hys_i) : '0;
        hot      = vld_i && (temp_i > lim_i);
        cool_now = vld_i ? (temp_i < thr) : s_q.cool;
        s_d.cool = cool_now;
        s_d.sts  = (s_q.sts && !(rd_clr_i && cool_now)) || hot;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.cool <= 1'b1;
            s_q.sts  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sts_o = s_q.sts;
endmodule

// File: rtl/limit_status_top.sv
`timescale 1ns/1ps
module limit_status_top
    import lcs_pkg::*;
#(
    parameter int unsigned NCH     = 2,
    parameter int unsigned NFAN    = 3,
    parameter int unsigned NDIO    = 2,
    parameter int unsigned DW      = 8,
    parameter int unsigned AW      = 4,
    parameter int unsigned OT_RST  = 100,
    parameter int unsigned HYS_RST = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NCH*DW-1:0] ch_meas_i,
    input  logic [NCH-1:0]    ch_vld_i,
    input  logic [DW-1:0]     temp_i,
    input  logic              temp_vld_i,
    input  logic [NFAN-1:0]   fan_slow_i,
    input  logic [NFAN-1:0]   pwm_on_i,
    input  logic [NDIO-1:0]   diode_flt_i,
    input  logic              data_err_i,
    input  logic [15:0]       err_code_i,
    input  logic              comm_err_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [AW-1:0]     reg_addr_i,
    input  logic [DW-1:0]     reg_wdata_i,
    output logic [DW-1:0]     reg_rdata_o,
    output logic              irq_o
);
    localparam int unsigned S1_SUM = NCH;
    localparam int unsigned S1_FAN = NCH + 1;
    localparam int unsigned S1_DIO = S1_FAN + NFAN;
    localparam int unsigned S1W    = S1_DIO + NDIO;

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] lo;
        logic [NCH-1:0][DW-1:0] hi;
        logic [DW-1:0]          tlo;
        logic [DW-1:0]          thi;
        logic [DW-1:0]          otl;
        logic [DW-1:0]          hys;
        logic [DW-1:0]          rdata;
        logic [2:0]             kind;
    } regs_t;

    regs_t r_d, r_q;

    logic            rd_s1, rd_s2;
    logic [NCH-1:0]  v_sts;
    logic [NFAN-1:0] fan_sts;
    logic [NDIO-1:0] dio_sts;
    logic            tw_sts, ot_sts, data_sts, comm_sts;
    logic [DW-1:0]   sts1, sts2;
    logic            summary;
    logic [DW-1:0]   lim0_lo, lim0_hi;

    assign rd_s1 = reg_rd_i && (reg_addr_i == AW'(ADR_STS1));
    assign rd_s2 = reg_rd_i && (reg_addr_i == AW'(ADR_STS2));

    // Voltage channels
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        lcs_window_chk #(.DW(DW)) u_win (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .meas_i   (ch_meas_i[g*DW +: DW]),
            .vld_i    (ch_vld_i[g]),
            .lo_i     (r_q.lo[g]),
            .hi_i     (r_q.hi[g]),
            .rd_clr_i (rd_s1),
            .sts_o    (v_sts[g])
        );
    end

    // Temperature window
    lcs_window_chk #(.DW(DW)) u_twin (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .meas_i   (temp_i),
        .vld_i    (temp_vld_i),
        .lo_i     (r_q.tlo),
        .hi_i     (r_q.thi),
        .rd_clr_i (rd_s2),
        .sts_o    (tw_sts)
    );

    lcs_overtemp #(.DW(DW)) u_ot (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .temp_i   (temp_i),
        .vld_i    (temp_vld_i),
        .lim_i    (r_q.otl),
        .hys_i    (r_q.hys),
        .rd_clr_i (rd_s2),
        .sts_o    (ot_sts)
    );

    // Fan faults count only while the PWM output is enabled
    lcs_sticky #(.W(NFAN)) u_fan (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .flt_i    (fan_slow_i & pwm_on_i),
        .rd_clr_i (rd_s1),
        .sts_o    (fan_sts)
    );

    lcs_sticky #(.W(NDIO)) u_dio (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .flt_i    (diode_flt_i),
        .rd_clr_i (rd_s1),
        .sts_o    (dio_sts)
    );

    lcs_sticky #(.W(2)) u_evt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .flt_i    ({comm_err_i, data_err_i}),
        .rd_clr_i (rd_s2),
        .sts_o    ({comm_sts, data_sts})
    );

    // Status register images
    always_comb begin
        sts2                   = '0;
        sts2[S2_TWIN]          = tw_sts;
        sts2[S2_DATA]          = data_sts;
        sts2[S2_COMM]          = comm_sts;
        sts2[S2_OVT]           = ot_sts;
        sts2[S2_KIND +: 3]     = r_q.kind;
        summary                = |sts2;
        sts1                   = '0;
        sts1[NCH-1:0]          = v_sts;
        sts1[S1_SUM]           = summary;
        sts1[S1_FAN +: NFAN]   = fan_sts;
        sts1[S1_DIO +: NDIO]   = dio_sts;
    end

    // Register file, error kind field and read data
    always_comb begin
        logic [DW-1:0] rd_val;
        r_d    = r_q;
        rd_val = '0;

        if (data_err_i)  r_d.kind = err_kind(err_code_i);
        else if (rd_s2)  r_d.kind = '0;

        if (reg_addr_i == AW'(ADR_STS1)) rd_val = sts1;
        if (reg_addr_i == AW'(ADR_STS2)) rd_val = sts2;
        if (reg_addr_i == AW'(ADR_TLO))  rd_val = r_q.tlo;
        if (reg_addr_i == AW'(ADR_THI))  rd_val = r_q.thi;
        if (reg_addr_i == AW'(ADR_OTL))  rd_val = r_q.otl;
        if (reg_addr_i == AW'(ADR_HYS))  rd_val = r_q.hys;
        for (int i = 0; i < NCH; i++) begin
            if (reg_addr_i == AW'(ADR_CH0 + 2*i))     rd_val = r_q.lo[i];
            if (reg_addr_i == AW'(ADR_CH0 + 2*i + 1)) rd_val = r_q.hi[i];
        end
        if (reg_rd_i) r_d.rdata = rd_val;

        if (reg_wr_i) begin
            if (reg_addr_i == AW'(ADR_TLO)) r_d.tlo = reg_wdata_i;
            if (reg_addr_i == AW'(ADR_THI)) r_d.thi = reg_wdata_i;
            if (reg_addr_i == AW'(ADR_OTL)) r_d.otl = reg_wdata_i;
            if (reg_addr_i == AW'(ADR_HYS)) r_d.hys = reg_wdata_i;
            for (int i = 0; i < NCH; i++) begin
                if (reg_addr_i == AW'(ADR_CH0 + 2*i))     r_d.lo[i] = reg_wdata_i;
                if (reg_addr_i == AW'(ADR_CH0 + 2*i + 1)) r_d.hi[i] = reg_wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.lo    <= '0;
            r_q.hi    <= '1;
            r_q.tlo   <= '0;
            r_q.thi   <= '1;
            r_q.otl   <= DW'(OT_RST);
            r_q.hys   <= DW'(HYS_RST);
            r_q.rdata <= '0;
            r_q.kind  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign lim0_lo     = r_q.lo[0];
    assign lim0_hi     = r_q.hi[0];
    assign reg_rdata_o = r_q.rdata;
    assign irq_o       = (|v_sts) | (|fan_sts) | (|dio_sts) | tw_sts | ot_sts | data_sts | comm_sts;
endmodule

// File: rtl/lcs_checker.sv
`timescale 1ns/1ps
module lcs_checker #(
    parameter int unsigned NCH  = 2,
    parameter int unsigned NFAN = 3,
    parameter int unsigned DW   = 8,
    parameter int unsigned AW   = 4
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [DW-1:0]   meas0,
    input logic            vld0,
    input logic [DW-1:0]   lo0,
    input logic [DW-1:0]   hi0,
    input logic            vsts0,
    input logic [NFAN-1:0] fan_sts,
    input logic [NFAN-1:0] fan_slow,
    input logic [NFAN-1:0] pwm_on,
    input logic            reg_rd,
    input logic [AW-1:0]   reg_addr,
    input logic [DW-1:0]   rdata,
    input logic [DW-1:0]   sts2,
    input logic            ot_sts,
    input logic [DW-1:0]   temp,
    input logic            temp_vld,
    input logic [DW-1:0]   otl
);
    // A channel bit rises only from a strobed sample outside the window
    p_rise_cause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(vsts0) |-> $past(vld0 && ((meas0 > hi0) || (meas0 <= lo0))));

    p_low_equal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld0 && (meas0 <= lo0)) |=> vsts0);

    p_clear_by_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(vsts0) |-> $past(reg_rd && (reg_addr == AW'(0))));

    p_fan_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fan_sts & ~$past(fan_sts) & ~$past(pwm_on)) == '0);

    p_summary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rd && (reg_addr == AW'(0))) |=> (rdata[NCH] == $past(|sts2)));

    p_ot_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (temp_vld && (temp > otl)) |=> ot_sts);

    p_read_cycle_fault_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rd && (reg_addr == AW'(0)) && ((fan_slow & pwm_on) != '0)) |=> (fan_sts != '0));
endmodule

bind limit_status_top lcs_checker #(
    .NCH (NCH),
    .NFAN(NFAN),
    .DW  (DW),
    .AW  (AW)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .meas0    (ch_meas_i[DW-1:0]),
    .vld0     (ch_vld_i[0]),
    .lo0      (lim0_lo),
    .hi0      (lim0_hi),
    .vsts0    (v_sts[0]),
    .fan_sts  (fan_sts),
    .fan_slow (fan_slow_i),
    .pwm_on   (pwm_on_i),
    .reg_rd   (reg_rd_i),
    .reg_addr (reg_addr_i),
    .rdata    (reg_rdata_o),
    .sts2     (sts2),
    .ot_sts   (ot_sts),
    .temp     (temp_i),
    .temp_vld (temp_vld_i),
    .otl      (r_q.otl)
);

// File: tb/sim_limit_status_top.sv
`timescale 1ns/1ps
module sim_limit_status_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] meas = '0;
    logic [1:0]  vld = '0;
    logic [7:0]  temp = '0;
    logic        tvld = 1'b0;
    logic [2:0]  slow = '0, pwm = '0;
    logic [1:0]  dio = '0;
    logic        derr = 1'b0, comm = 1'b0;
    logic [15:0] code = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    limit_status_top u0 (
        .clk_i(clk), .rst_ni(rst_n), .ch_meas_i(meas), .ch_vld_i(vld),
        .temp_i(temp), .temp_vld_i(tvld), .fan_slow_i(slow), .pwm_on_i(pwm),
        .diode_flt_i(dio), .data_err_i(derr), .err_code_i(code), .comm_err_i(comm),
        .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    // Expected state, derived from the requirements
    logic [7:0] m_lo [2];
    logic [7:0] m_hi [2];
    logic [7:0] m_tlo, m_thi, m_otl, m_hys;
    logic [1:0] m_vs, m_va, m_dio;
    logic [2:0] m_fan, m_kind;
    logic       m_tw, m_ta, m_data, m_comm, m_ot, m_cool;

    function automatic logic [2:0] kind_of(input logic [15:0] c);
        if (c == 16'h8000) return 3'b000;
        if (c == 16'h8002) return 3'b001;
        if (c == 16'h8003) return 3'b010;
        return 3'b111;
    endfunction

    function automatic logic [7:0] s2v();
        return {1'b0, m_kind, m_ot, m_comm, m_data, m_tw};
    endfunction

    function automatic logic [7:0] s1v();
        return {m_dio, m_fan, |s2v(), m_vs};
    endfunction

    function automatic logic [7:0] model_read(input logic [3:0] a);
        case (a)
            4'd0: return s1v();
            4'd1: return s2v();
            4'd2: return m_tlo;
            4'd3: return m_thi;
            4'd4: return m_otl;
            4'd5: return m_hys;
            4'd6: return m_lo[0];
            4'd7: return m_hi[0];
            4'd8: return m_lo[1];
            4'd9: return m_hi[1];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_lo[0] = 8'h00; m_lo[1] = 8'h00; m_hi[0] = 8'hFF; m_hi[1] = 8'hFF;
        m_tlo = 8'h00; m_thi = 8'hFF; m_otl = 8'd100; m_hys = 8'd4;
        m_vs = '0; m_va = '0; m_dio = '0; m_fan = '0; m_kind = '0;
        m_tw = 0; m_ta = 0; m_data = 0; m_comm = 0; m_ot = 0; m_cool = 1;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: predict, advance, compare
    task automatic step();
        logic [7:0] exp_rd;
        logic       rd_chk, rc1, rc2;
        logic [3:0] a_chk;
        logic [1:0] n_vs, n_va;
        logic [2:0] n_fan, n_kind, f;
        logic [1:0] n_dio;
        logic       n_tw, n_ta, n_data, n_comm, n_ot, n_cool, o, cnd, hot;
        logic [7:0] mv, thr;
        exp_rd = model_read(addr);
        rd_chk = rd;
        a_chk  = addr;
        rc1 = rd && (addr == 4'd0);
        rc2 = rd && (addr == 4'd1);
        for (int i = 0; i < 2; i++) begin
            mv = meas[i*8 +: 8];
            o = vld[i] && ((mv > m_hi[i]) || (mv <= m_lo[i]));
            cnd = vld[i] ? o : m_va[i];
            n_va[i] = cnd;
            n_vs[i] = (m_vs[i] && !(rc1 && !cnd)) || o;
        end
        o = tvld && ((temp > m_thi) || (temp <= m_tlo));
        cnd = tvld ? o : m_ta;
        n_ta = cnd;
        n_tw = (m_tw && !(rc2 && !cnd)) || o;
        f = slow & pwm;
        n_fan = (m_fan & ~({3{rc1}} & ~f)) | f;
        n_dio = (m_dio & ~({2{rc1}} & ~dio)) | dio;
        n_data = (m_data && !rc2) || derr;
        n_comm = (m_comm && !rc2) || comm;
        n_kind = derr ? kind_of(code) : (rc2 ? 3'b000 : m_kind);
        thr = (m_otl > m_hys) ? (m_otl - m_hys) : 8'h00;
        hot = tvld && (temp > m_otl);
        n_cool = tvld ? (temp < thr) : m_cool;
        n_ot = (m_ot && !(rc2 && n_cool)) || hot;
        @(posedge clk);
        #1;
        m_vs = n_vs; m_va = n_va; m_tw = n_tw; m_ta = n_ta; m_fan = n_fan;
        m_dio = n_dio; m_data = n_data; m_comm = n_comm; m_kind = n_kind;
        m_ot = n_ot; m_cool = n_cool;
        if (wr) begin
            case (a_chk)
                4'd2: m_tlo = wdata;
                4'd3: m_thi = wdata;
                4'd4: m_otl = wdata;
                4'd5: m_hys = wdata;
                4'd6: m_lo[0] = wdata;
                4'd7: m_hi[0] = wdata;
                4'd8: m_lo[1] = wdata;
                4'd9: m_hi[1] = wdata;
                default: ;
            endcase
        end
        if (rd_chk) begin
            if (a_chk == 4'd0)      chk("R4 status1 read", {8'h00, rdata}, {8'h00, exp_rd});
            else if (a_chk == 4'd1) chk("R13 status2 read", {8'h00, rdata}, {8'h00, exp_rd});
            else                    chk("R9 register read", {8'h00, rdata}, {8'h00, exp_rd});
        end
        chk("R11 irq", {15'h0, irq}, {15'h0, ((s1v() | s2v()) != 8'h00)});
    endtask

    task automatic wreg(input logic [3:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        step();
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [3:0] a, output logic [7:0] d);
        rd = 1'b1; addr = a;
        step();
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic sample0(input logic [7:0] v);
        meas[7:0] = v; vld = 2'b01;
        step();
        vld = 2'b00;
    endtask

    task automatic sample_t(input logic [7:0] v);
        temp = v; tvld = 1'b1;
        step();
        tvld = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] d;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R3: reset values
        rreg(4'd6, d); chk("R3 low limit reset", {8'h0, d}, 16'h0000);
        rreg(4'd7, d); chk("R3 high limit reset", {8'h0, d}, 16'h00FF);
        rreg(4'd4, d); chk("R3 over-temp limit reset", {8'h0, d}, 16'd100);
        rreg(4'd5, d); chk("R3 hysteresis reset", {8'h0, d}, 16'd4);
        rreg(4'd0, d); chk("R3 status1 reset", {8'h0, d}, 16'h0000);
        rreg(4'd1, d); chk("R3 status2 reset", {8'h0, d}, 16'h0000);
        chk("R3 irq reset", {15'h0, irq}, 16'h0000);

        // R9: limits writable and readable
        wreg(4'd6, 8'h40);
        wreg(4'd7, 8'hC0);
        rreg(4'd6, d); chk("R9 low limit readback", {8'h0, d}, 16'h0040);
        rreg(4'd7, d); chk("R9 high limit readback", {8'h0, d}, 16'h00C0);
        rreg(4'd12, d); chk("R9 unmapped reads zero", {8'h0, d}, 16'h0000);

        // R2: equality trips the low limit
        sample0(8'h40);
        rreg(4'd0, d); chk("R2 low equal trips", {15'h0, d[0]}, 16'h0001);
        // R4: fault still present, read keeps the bit
        rreg(4'd0, d); chk("R4 bit held while fault present", {15'h0, d[0]}, 16'h0001);
        // R12: no strobe, no new comparison; in-range sample ends the fault
        meas[7:0] = 8'h80; step(); step();
        rreg(4'd0, d); chk("R12 stale value ignored, bit still set", {15'h0, d[0]}, 16'h0001);
        sample0(8'h80);
        rreg(4'd0, d); chk("R4 read returns pre-clear value", {15'h0, d[0]}, 16'h0001);
        rreg(4'd0, d); chk("R4 cleared once fault gone", {15'h0, d[0]}, 16'h0000);

        // R1: strictly greater
        sample0(8'hC0);
        rreg(4'd0, d); chk("R1 high equal does not trip", {15'h0, d[0]}, 16'h0000);
        sample0(8'hC1);
        rreg(4'd0, d); chk("R1 above high trips", {15'h0, d[0]}, 16'h0001);
        sample0(8'h80);
        rreg(4'd0, d);
        rreg(4'd0, d); chk("R4 high fault cleared", {15'h0, d[0]}, 16'h0000);

        // R10: fault arriving in the read cycle survives the read
        meas[7:0] = 8'hC1; vld = 2'b01; rd = 1'b1; addr = 4'd0;
        step();
        vld = 2'b00; rd = 1'b0;
        chk("R10 read before new fault", {15'h0, rdata[0]}, 16'h0000);
        rreg(4'd0, d); chk("R10 new fault kept", {15'h0, d[0]}, 16'h0001);
        sample0(8'h80);
        rreg(4'd0, d);

        // R5: fan fault masked while PWM off
        slow = 3'b001; pwm = 3'b000;
        step(); step();
        rreg(4'd0, d); chk("R5 fan masked with PWM off", {13'h0, d[5:3]}, 16'h0000);
        pwm = 3'b001; step();
        rreg(4'd0, d); chk("R5 fan bit with PWM on", {13'h0, d[5:3]}, 16'h0001);
        slow = 3'b000;
        rreg(4'd0, d);
        rreg(4'd0, d); chk("R4 fan bit cleared", {13'h0, d[5:3]}, 16'h0000);
        pwm = 3'b000;

        // R6, R13: summary follows status2, not latched
        comm = 1'b1; step(); comm = 1'b0;
        chk("R11 irq on comm error", {15'h0, irq}, 16'h0001);
        rreg(4'd0, d); chk("R6 summary set", {15'h0, d[2]}, 16'h0001);
        rreg(4'd1, d); chk("R13 comm bit", {15'h0, d[2]}, 16'h0001);
        rreg(4'd0, d); chk("R6 summary follows clear", {15'h0, d[2]}, 16'h0000);
        chk("R11 irq low when clear", {15'h0, irq}, 16'h0000);

        // R8: error kind encodings
        begin
            logic [15:0] codes [4];
            logic [2:0]  kinds [4];
            codes[0] = 16'h8000; kinds[0] = 3'b000;
            codes[1] = 16'h8002; kinds[1] = 3'b001;
            codes[2] = 16'h8003; kinds[2] = 3'b010;
            codes[3] = 16'h1234; kinds[3] = 3'b111;
            for (int k = 0; k < 4; k++) begin
                derr = 1'b1; code = codes[k]; step(); derr = 1'b0;
                rreg(4'd1, d);
                chk("R8 error kind field", {12'h0, d[1], d[6:4]}, {12'h0, 1'b1, kinds[k]});
                rreg(4'd1, d);
                chk("R8 field cleared with data bit", {8'h0, d}, 16'h0000);
            end
        end

        // R7: over-temperature with hysteresis (limit 100, hysteresis 4)
        sample_t(8'd101);
        rreg(4'd1, d); chk("R7 over-temp set", {15'h0, d[3]}, 16'h0001);
        sample_t(8'd97);
        rreg(4'd1, d);
        rreg(4'd1, d); chk("R7 held above release threshold", {15'h0, d[3]}, 16'h0001);
        sample_t(8'd96);
        rreg(4'd1, d);
        rreg(4'd1, d); chk("R7 held at release threshold", {15'h0, d[3]}, 16'h0001);
        sample_t(8'd95);
        rreg(4'd1, d);
        rreg(4'd1, d); chk("R7 cleared below threshold", {15'h0, d[3]}, 16'h0000);

        // Constrained random phase
        void'($urandom(32'd20240611));
        for (int n = 0; n < 4000; n++) begin
            meas  = 16'($urandom);
            vld   = 2'($urandom_range(0, 3) == 0 ? $urandom : 0);
            temp  = 8'($urandom_range(80, 120));
            if ($urandom_range(0, 15) == 0) temp = 8'($urandom);
            tvld  = ($urandom_range(0, 2) == 0);
            slow  = 3'($urandom);
            pwm   = 3'($urandom);
            dio   = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
            derr  = ($urandom_range(0, 15) == 0);
            case ($urandom_range(0, 3))
                0: code = 16'h8000;
                1: code = 16'h8002;
                2: code = 16'h8003;
                default: code = 16'($urandom);
            endcase
            comm  = ($urandom_range(0, 15) == 0);
            rd    = ($urandom_range(0, 2) == 0);
            addr  = ($urandom_range(0, 3) != 0) ? 4'($urandom_range(0, 1)) : 4'($urandom);
            wr    = ($urandom_range(0, 15) == 0);
            wdata = 8'($urandom);
            if (wr && !rd) addr = 4'($urandom_range(2, 9));
            step();
        end
        rd = 0; wr = 0; vld = 0; tvld = 0; derr = 0; comm = 0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule